// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core whether a load or store that is being dispatched must wait behind an older in-flight store, and which store that is. Memory instructions are grouped into store sets. A set-ID table, indexed by instruction address, maps each instruction to its set. A per-set table holds the tag of the youngest store of that set that has been fetched and has not yet issued. When the core detects a memory-order violation, it reports the store PC and the load PC, and the predictor merges the two instructions into one set. When a store issues, its entry in the per-set table is retired, but only if a younger store of the same set has not already replaced it.

The block has its own counter of load and store lookups. When the count passes a period that the integrator programs at run time, every entry of both tables is flash-invalidated in a single cycle. Without this, sets that have gone stale would keep making unrelated accesses look dependent. A suitable period is 250000 lookups, which the package exports as a constant.

All responses are registered and appear one cycle after the request. Every port can be active in the same cycle.

Top module: `store_set_pred`

## Requirements
- R1: Each load lookup and each store lookup adds one to the operation count. A cycle with both adds two. Violation and issue reports do not count.
- R2: If adding the cycle's lookups would make the count strictly greater than `period`, the count returns to zero and every set-ID entry, every per-set entry and the set allocator are cleared. Lookups in that cycle are answered as independent, and store insertion, violation and issue updates in that cycle are discarded.
- R3: The set-ID index of a PC is (PC >> 2) masked with (SSIT_ENTRIES − 1). PCs that differ only in bits [1:0] or above that field share an entry.
- R4: A load or store whose set-ID entry is invalid is answered independent: `*_wait` = 0 and `*_wait_tag` = 0.
- R5: A violation in which neither PC has a valid set ID gives both PCs the value of a rotating allocator. The allocator starts at 0 after reset or a wipe, and advances by one modulo LFST_ENTRIES.
- R6: A violation in which exactly one PC has a valid set ID copies that ID to the other PC.
- R7: A violation in which both PCs have valid set IDs gives both the smaller of the two IDs.
- R8: A load whose set has a valid per-set entry is answered `ld_wait` = 1, with `ld_wait_tag` equal to the stored tag.
- R9: A store whose set has a valid per-set entry is answered with a wait on the tag held there. The store's own tag is then written into that entry, which becomes valid. A store with an invalid set ID writes nothing.
- R10: An issue report invalidates its set's per-set entry only when that entry holds the issuing tag. A store insertion into the same set in the same cycle wins.
- R11: `*_rsp_valid` follows the request by exactly one cycle. Lookups see table state from before that cycle's updates, wipes excepted. All outputs are 0 in reset.
- R12: `period` is sampled every cycle, so a new value takes effect on the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | PERIOD_W | Lookups allowed between wipes |
| ld_req | input | 1 | Load lookup request |
| ld_pc | input | PC_W | Load instruction address |
| st_req | input | 1 | Store lookup-and-insert request |
| st_pc | input | PC_W | Store instruction address |
| st_tag | input | TAG_W | In-flight tag of the inserted store |
| vio_req | input | 1 | Violation report |
| vio_st_pc | input | PC_W | PC of the older store in the violation |
| vio_ld_pc | input | PC_W | PC of the younger load in the violation |
| iss_req | input | 1 | Store issue report |
| iss_pc | input | PC_W | PC of the issuing store |
| iss_tag | input | TAG_W | Tag of the issuing store |
| ld_rsp_valid | output | 1 | Load answer valid |
| ld_wait | output | 1 | Load must wait |
| ld_wait_tag | output | TAG_W | Store tag the load waits on |
| st_rsp_valid | output | 1 | Store answer valid |
| st_wait | output | 1 | Store must wait |
| st_wait_tag | output | TAG_W | Previous store tag the store waits on |

## Verification
The bench builds the predictor with a 16-entry set-ID table, an 8-entry per-set table, 6-bit tags and an 18-bit period. The small set-ID table makes random PCs alias often, so merges in which both IDs are valid arise naturally. The 8-entry per-set table makes the allocator wrap within a short run. Random phases run with a period of 37, which triggers many wipes, including wipes that coincide with dual lookups, violations and issues. A later phase uses the largest 18-bit period. Directed sequences cover the three merge cases, tag-matched retirement and alias indexing.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Suggested run-time wipe period in lookups.
  localparam int unsigned SSP_DEFAULT_PERIOD = 250000;

  // How a violation report rewrites the set-ID table.
  typedef enum logic [1:0] {
    MRG_NEW_SET  = 2'd0,
    MRG_FROM_ST  = 2'd1,
    MRG_FROM_LD  = 2'd2,
    MRG_TAKE_MIN = 2'd3
  } merge_e;

endpackage

// File: rtl/ssp_opcount.sv
module ssp_opcount #(
  parameter int PERIOD_W = 20,
  localparam int CNT_W = PERIOD_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_op,
  input  logic                st_op,
  input  logic [PERIOD_W-1:0] period,
  output logic                wipe,
  output logic [CNT_W-1:0]    cnt
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt + CNT_W'(ld_op) + CNT_W'(st_op);
    wipe    = cnt_nxt > {1'b0, period};
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) cnt <= '0;
    else             cnt <= cnt_nxt;
  end

endmodule

// File: rtl/ssp_ssit.sv
module ssp_ssit #(
  parameter int ENTRIES  = 1024,
  parameter int ID_W     = 10,
  parameter int RD_PORTS = 5,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wipe,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx,
  output logic [RD_PORTS-1:0]                rd_vld,
  output logic [RD_PORTS-1:0][ID_W-1:0]      rd_id,
  input  logic [1:0]                         wr_en,
  input  logic [1:0][IDX_W-1:0]              wr_idx,
  input  logic [1:0][ID_W-1:0]               wr_id
);

  logic [ENTRIES-1:0] vld;
  logic [ID_W-1:0]    ids [ENTRIES];

  // Valid bits in flops for the single-cycle flash clear.
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      vld <= '0;
    end else begin
      for (int w = 0; w < 2; w++)
        if (wr_en[w]) vld[wr_idx[w]] <= 1'b1;
    end
  end

  // Payload array carries no reset, so it maps to RAM.
  always_ff @(posedge clk) begin
    for (int w = 0; w < 2; w++)
      if (wr_en[w] && !wipe) ids[wr_idx[w]] <= wr_id[w];
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_vld[p] = vld[rd_idx[p]];
    assign rd_id[p]  = ids[rd_idx[p]];
  end

endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
  parameter int ENTRIES  = 1024,
  parameter int TAG_W    = 8,
  parameter int RD_PORTS = 2,
  localparam int ID_W    = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wipe,
  input  logic [RD_PORTS-1:0][ID_W-1:0]     rd_id,
  output logic [RD_PORTS-1:0]               rd_vld,
  output logic [RD_PORTS-1:0][TAG_W-1:0]    rd_tag,
  input  logic                              set_en,
  input  logic [ID_W-1:0]                   set_id,
  input  logic [TAG_W-1:0]                  set_tag,
  input  logic                              clr_req,
  input  logic [ID_W-1:0]                   clr_id,
  input  logic [TAG_W-1:0]                  clr_tag
);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic               clr_hit;

  assign clr_hit = clr_req && vld[clr_id] && (tags[clr_id] == clr_tag);

  // The insertion is applied after the clear, so it wins on a shared set.
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      vld <= '0;
    end else begin
      if (clr_hit) vld[clr_id] <= 1'b0;
      if (set_en)  vld[set_id] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en && !wipe) tags[set_id] <= set_tag;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_vld[p] = vld[rd_id[p]];
    assign rd_tag[p] = tags[rd_id[p]];
  end

endmodule

// File: rtl/ssp_merge.sv
module ssp_merge
  import ssp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int ID_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wipe,
  input  logic                   req,
  input  logic [IDX_W-1:0]       st_idx,
  input  logic [IDX_W-1:0]       ld_idx,
  input  logic                   st_vld,
  input  logic [ID_W-1:0]        st_id,
  input  logic                   ld_vld,
  input  logic [ID_W-1:0]        ld_id,
  output logic [1:0]             wr_en,
  output logic [1:0][IDX_W-1:0]  wr_idx,
  output logic [1:0][ID_W-1:0]   wr_id
);

  merge_e          kind;
  logic [ID_W-1:0] alloc;
  logic [ID_W-1:0] lower;

  always_comb begin
    unique case ({st_vld, ld_vld})
      2'b00:   kind = MRG_NEW_SET;
      2'b10:   kind = MRG_FROM_ST;
      2'b01:   kind = MRG_FROM_LD;
      default: kind = MRG_TAKE_MIN;
    endcase
    lower     = (st_id < ld_id) ? st_id : ld_id;
    wr_idx[0] = st_idx;
    wr_idx[1] = ld_idx;
    wr_id[0]  = st_id;
    wr_id[1]  = ld_id;
    wr_en     = 2'b00;
    if (req) begin
      unique case (kind)
        MRG_NEW_SET:  begin wr_en = 2'b11; wr_id[0] = alloc; wr_id[1] = alloc; end
        MRG_FROM_ST:  begin wr_en = 2'b10; wr_id[1] = st_id; end
        MRG_FROM_LD:  begin wr_en = 2'b01; wr_id[0] = ld_id; end
        MRG_TAKE_MIN: begin wr_en = 2'b11; wr_id[0] = lower; wr_id[1] = lower; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe)                     alloc <= '0;
    else if (req && kind == MRG_NEW_SET) alloc <= alloc + 1'b1;
  end

endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int PC_W         = 32,
  parameter int SSIT_ENTRIES = 1024,
  parameter int LFST_ENTRIES = 1024,
  parameter int TAG_W        = 8,
  parameter int PERIOD_W     = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  input  logic                ld_req,
  input  logic [PC_W-1:0]     ld_pc,
  input  logic                st_req,
  input  logic [PC_W-1:0]     st_pc,
  input  logic [TAG_W-1:0]    st_tag,
  input  logic                vio_req,
  input  logic [PC_W-1:0]     vio_st_pc,
  input  logic [PC_W-1:0]     vio_ld_pc,
  input  logic                iss_req,
  input  logic [PC_W-1:0]     iss_pc,
  input  logic [TAG_W-1:0]    iss_tag,
  output logic                ld_rsp_valid,
  output logic                ld_wait,
  output logic [TAG_W-1:0]    ld_wait_tag,
  output logic                st_rsp_valid,
  output logic                st_wait,
  output logic [TAG_W-1:0]    st_wait_tag
);

  localparam int IDX_W    = $clog2(SSIT_ENTRIES);
  localparam int ID_W     = $clog2(LFST_ENTRIES);
  localparam int CNT_W    = PERIOD_W + 1;
  localparam int PC_SHIFT = 2;
  // Set-ID table read ports.
  localparam int P_LD = 0, P_ST = 1, P_ISS = 2, P_VST = 3, P_VLD = 4;

  function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
    return IDX_W'((pc >> PC_SHIFT) & PC_W'(SSIT_ENTRIES - 1));
  endfunction

  logic                          wipe;
  logic [CNT_W-1:0]              op_cnt;
  logic [4:0][IDX_W-1:0]         ssit_idx;
  logic [4:0]                    ssit_vld;
  logic [4:0][ID_W-1:0]          ssit_id;
  logic [1:0]                    vio_wr_en;
  logic [1:0][IDX_W-1:0]         vio_wr_idx;
  logic [1:0][ID_W-1:0]          vio_wr_id;
  logic [1:0][ID_W-1:0]          lfst_rd_id;
  logic [1:0]                    lfst_vld;
  logic [1:0][TAG_W-1:0]         lfst_tag;
  logic                          st_set_en;
  logic                          iss_clr;
  logic                          ld_hit;
  logic                          st_hit;

  ssp_opcount #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst(rst), .ld_op(ld_req), .st_op(st_req),
    .period(period), .wipe(wipe), .cnt(op_cnt)
  );

  always_comb begin
    ssit_idx[P_LD]  = pc_index(ld_pc);
    ssit_idx[P_ST]  = pc_index(st_pc);
    ssit_idx[P_ISS] = pc_index(iss_pc);
    ssit_idx[P_VST] = pc_index(vio_st_pc);
    ssit_idx[P_VLD] = pc_index(vio_ld_pc);
  end

  ssp_ssit #(.ENTRIES(SSIT_ENTRIES), .ID_W(ID_W), .RD_PORTS(5)) u_ssit (
    .clk(clk), .rst(rst), .wipe(wipe),
    .rd_idx(ssit_idx), .rd_vld(ssit_vld), .rd_id(ssit_id),
    .wr_en(vio_wr_en), .wr_idx(vio_wr_idx), .wr_id(vio_wr_id)
  );

  ssp_merge #(.IDX_W(IDX_W), .ID_W(ID_W)) u_merge (
    .clk(clk), .rst(rst), .wipe(wipe), .req(vio_req && !wipe),
    .st_idx(ssit_idx[P_VST]), .ld_idx(ssit_idx[P_VLD]),
    .st_vld(ssit_vld[P_VST]), .st_id(ssit_id[P_VST]),
    .ld_vld(ssit_vld[P_VLD]), .ld_id(ssit_id[P_VLD]),
    .wr_en(vio_wr_en), .wr_idx(vio_wr_idx), .wr_id(vio_wr_id)
  );

  assign lfst_rd_id[0] = ssit_id[P_LD];
  assign lfst_rd_id[1] = ssit_id[P_ST];
  assign st_set_en     = st_req && ssit_vld[P_ST] && !wipe;
  assign iss_clr       = iss_req && ssit_vld[P_ISS] && !wipe;

  ssp_lfst #(.ENTRIES(LFST_ENTRIES), .TAG_W(TAG_W), .RD_PORTS(2)) u_lfst (
    .clk(clk), .rst(rst), .wipe(wipe),
    .rd_id(lfst_rd_id), .rd_vld(lfst_vld), .rd_tag(lfst_tag),
    .set_en(st_set_en), .set_id(ssit_id[P_ST]), .set_tag(st_tag),
    .clr_req(iss_clr), .clr_id(ssit_id[P_ISS]), .clr_tag(iss_tag)
  );

  assign ld_hit = ld_req && !wipe && ssit_vld[P_LD] && lfst_vld[0];
  assign st_hit = st_req && !wipe && ssit_vld[P_ST] && lfst_vld[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rsp_valid <= 1'b0;
      ld_wait      <= 1'b0;
      ld_wait_tag  <= '0;
      st_rsp_valid <= 1'b0;
      st_wait      <= 1'b0;
      st_wait_tag  <= '0;
    end else begin
      ld_rsp_valid <= ld_req;
      ld_wait      <= ld_hit;
      ld_wait_tag  <= ld_hit ? lfst_tag[0] : '0;
      st_rsp_valid <= st_req;
      st_wait      <= st_hit;
      st_wait_tag  <= st_hit ? lfst_tag[1] : '0;
    end
  end

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int PERIOD_W = 20,
  localparam int CNT_W = PERIOD_W + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                ld_req,
  input logic                st_req,
  input logic                ld_rsp_valid,
  input logic                st_rsp_valid,
  input logic                ld_wait,
  input logic                st_wait,
  input logic                wipe,
  input logic [CNT_W-1:0]    cnt,
  input logic [PERIOD_W-1:0] period
);

  assert_ld_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> ld_rsp_valid);
  assert_st_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    st_req |=> st_rsp_valid);
  assert_ld_wait_needs_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    ld_wait |-> ld_rsp_valid);
  assert_st_wait_needs_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    st_wait |-> st_rsp_valid);
  assert_wipe_zeroes_count_R2: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (cnt == '0));
  assert_wipe_answers_free_R2: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (!ld_wait && !st_wait));
  assert_single_op_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!wipe && ld_req && !st_req) |=> (cnt == $past(cnt) + 1'b1));
  assert_idle_holds_count_R1: assert property (@(posedge clk) disable iff (rst)
    (!wipe && !ld_req && !st_req) |=> $stable(cnt));
  assert_count_within_period_R12: assert property (@(posedge clk) disable iff (rst)
    !wipe |=> (cnt <= {1'b0, $past(period)}));

endmodule

bind store_set_pred ssp_checker #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req),
  .ld_rsp_valid(ld_rsp_valid), .st_rsp_valid(st_rsp_valid),
  .ld_wait(ld_wait), .st_wait(st_wait),
  .wipe(wipe), .cnt(op_cnt), .period(period)
);

// File: tb/store_set_pred_test.sv
`timescale 1ns/1ps
module store_set_pred_test;

  localparam int PC_W = 32, NS = 16, NL = 8, TW = 6, PW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0]   period = '0;
  logic            ld_req = 0, st_req = 0, vio_req = 0, iss_req = 0;
  logic [PC_W-1:0] ld_pc = '0, st_pc = '0, vio_st_pc = '0, vio_ld_pc = '0, iss_pc = '0;
  logic [TW-1:0]   st_tag = '0, iss_tag = '0;
  logic            ld_rsp_valid, ld_wait, st_rsp_valid, st_wait;
  logic [TW-1:0]   ld_wait_tag, st_wait_tag;

  always #2 clk = ~clk;

  store_set_pred #(.PC_W(PC_W), .SSIT_ENTRIES(NS), .LFST_ENTRIES(NL),
                   .TAG_W(TW), .PERIOD_W(PW)) uut (
    .clk(clk), .rst(rst), .period(period),
    .ld_req(ld_req), .ld_pc(ld_pc), .st_req(st_req), .st_pc(st_pc), .st_tag(st_tag),
    .vio_req(vio_req), .vio_st_pc(vio_st_pc), .vio_ld_pc(vio_ld_pc),
    .iss_req(iss_req), .iss_pc(iss_pc), .iss_tag(iss_tag),
    .ld_rsp_valid(ld_rsp_valid), .ld_wait(ld_wait), .ld_wait_tag(ld_wait_tag),
    .st_rsp_valid(st_rsp_valid), .st_wait(st_wait), .st_wait_tag(st_wait_tag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  bit m_sv[NS]; int m_sid[NS];
  bit m_lv[NL]; int m_ltag[NL];
  int m_cnt = 0, m_alloc = 0;
  int period_set = 1000;

  // Expected responses for the request now in flight
  bit e_lv = 0, e_lw = 0, e_sv = 0, e_sw = 0;
  int e_lt = 0, e_st = 0;
  string e_req = "R11 reset";

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> 2) % NS);
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_step(bit ld, logic [PC_W-1:0] lpc, bit st, logic [PC_W-1:0] spc,
                            int stg, bit vio, logic [PC_W-1:0] vs, logic [PC_W-1:0] vl,
                            bit iss, logic [PC_W-1:0] ipc, int itg);
    int li = idx_of(lpc), si = idx_of(spc), ii = idx_of(ipc);
    int vsi = idx_of(vs), vli = idx_of(vl);
    int nxt = m_cnt + int'(ld) + int'(st);
    bit s_ok = m_sv[si], i_ok = m_sv[ii];
    int s_set = m_sid[si], i_set = m_sid[ii];
    bit a = m_sv[vsi], b = m_sv[vli];
    int ai = m_sid[vsi], bi = m_sid[vli];
    e_lv = ld; e_sv = st; e_lw = 0; e_lt = 0; e_sw = 0; e_st = 0;
    if (nxt > period_set) begin
      m_cnt = 0; m_alloc = 0;
      for (int k = 0; k < NS; k++) m_sv[k] = 0;
      for (int k = 0; k < NL; k++) m_lv[k] = 0;
      return;
    end
    m_cnt = nxt;
    if (ld && m_sv[li] && m_lv[m_sid[li]]) begin e_lw = 1; e_lt = m_ltag[m_sid[li]]; end
    if (st && s_ok && m_lv[s_set]) begin e_sw = 1; e_st = m_ltag[s_set]; end
    if (iss && i_ok && m_lv[i_set] && m_ltag[i_set] == itg) m_lv[i_set] = 0;
    if (st && s_ok) begin m_lv[s_set] = 1; m_ltag[s_set] = stg; end
    if (vio) begin
      if (!a && !b) begin
        m_sid[vsi] = m_alloc; m_sid[vli] = m_alloc; m_alloc = (m_alloc + 1) % NL;
      end else if (a && !b) m_sid[vli] = ai;
      else if (!a && b) m_sid[vsi] = bi;
      else begin m_sid[vsi] = min2(ai, bi); m_sid[vli] = min2(ai, bi); end
      m_sv[vsi] = 1; m_sv[vli] = 1;
    end
  endtask

  task automatic check_outputs();
    checks++;
    if ({ld_rsp_valid, ld_wait} !== {e_lv, e_lw} || int'(ld_wait_tag) != e_lt) begin
      errors++;
      $display("FAIL %s load: got v=%0d w=%0d t=%0d expected v=%0d w=%0d t=%0d",
               e_req, ld_rsp_valid, ld_wait, ld_wait_tag, e_lv, e_lw, e_lt);
    end
    checks++;
    if ({st_rsp_valid, st_wait} !== {e_sv, e_sw} || int'(st_wait_tag) != e_st) begin
      errors++;
      $display("FAIL %s store: got v=%0d w=%0d t=%0d expected v=%0d w=%0d t=%0d",
               e_req, st_rsp_valid, st_wait, st_wait_tag, e_sv, e_sw, e_st);
    end
  endtask

  task automatic cyc(string r, bit ld, logic [PC_W-1:0] lpc, bit st, logic [PC_W-1:0] spc,
                     int stg, bit vio, logic [PC_W-1:0] vs, logic [PC_W-1:0] vl,
                     bit iss, logic [PC_W-1:0] ipc, int itg);
    @(negedge clk);
    check_outputs();
    period = PW'(period_set);
    ld_req = ld; ld_pc = lpc; st_req = st; st_pc = spc; st_tag = TW'(stg);
    vio_req = vio; vio_st_pc = vs; vio_ld_pc = vl;
    iss_req = iss; iss_pc = ipc; iss_tag = TW'(itg);
    model_step(ld, lpc, st, spc, stg, vio, vs, vl, iss, ipc, itg);
    e_req = r;
  endtask

  task automatic ldq(string r, logic [PC_W-1:0] pc);
    cyc(r, 1, pc, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic stq(string r, logic [PC_W-1:0] pc, int tg);
    cyc(r, 0, 0, 1, pc, tg, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic vio(string r, logic [PC_W-1:0] s, logic [PC_W-1:0] l);
    cyc(r, 0, 0, 0, 0, 0, 1, s, l, 0, 0, 0);
  endtask
  task automatic iss(string r, logic [PC_W-1:0] pc, int tg);
    cyc(r, 0, 0, 0, 0, 0, 0, 0, 0, 1, pc, tg);
  endtask

  localparam logic [PC_W-1:0] PA = 32'h1004, PB = 32'h2008, PC = 32'h300C,
                              PD = 32'h4010, PE = 32'h5014, PB_ALIAS = 32'h204B;

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    ldq("R4", PB);                 // unknown PC, independent
    vio("R5", PA, PB);             // new set 0
    stq("R9", PA, 5);              // no prior store
    ldq("R8", PB);                 // waits on 5
    stq("R9", PA, 9);              // waits on 5, installs 9
    iss("R10", PA, 5);             // tag mismatch, kept
    ldq("R10", PB);                // still 9
    iss("R10", PA, 9);             // match, cleared
    ldq("R10", PB);                // free
    stq("R3", PA, 12);
    ldq("R3", PB_ALIAS);           // aliases PB, waits 12
    vio("R6", PC, PB);             // PC joins set 0
    stq("R6", PC, 20);             // waits 12
    ldq("R6", PB);                 // waits 20
    vio("R5", PD, PE);             // new set 1
    stq("R7", PD, 30);
    vio("R7", PD, PB);             // min(1,0)=0
    stq("R7", PD, 31);             // waits 20
    cyc("R11", 1, PB, 1, PA, 33, 0, 0, 0, 0, 0, 0);  // ld sees 31, st waits 31
    period_set = m_cnt;            // next lookup exceeds
    ldq("R2", PB);                 // wipe cycle, independent
    ldq("R2", PB);
    stq("R2", PA, 1);
    period_set = 2;
    vio("R12", PA, PB);
    stq("R12", PA, 3);
    ldq("R12", PB);
    ldq("R12", PB);

    period_set = 37;
    for (int n = 0; n < 3000; n++)
      cyc("random R1", 1'($urandom), $urandom, 1'($urandom), $urandom, int'($urandom % 8),
          1'($urandom), $urandom, $urandom, 1'($urandom), $urandom, int'($urandom % 8));
    period_set = (1 << PW) - 1;
    for (int n = 0; n < 1000; n++)
      cyc("random R12", 1'($urandom), $urandom, 1'($urandom), $urandom, int'($urandom % 8),
          1'($urandom), $urandom, $urandom, 1'($urandom), $urandom, int'($urandom % 8));
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule